// File: doc/BRIEF.md
# Reset Key Timer and Status Lamp Driver

This block watches a single debounced, active-low reset key and decides what a press means. A press that is released before a fixed hold time asks only for the playback position to go back to the start. A press held until that hold time asks for a full wipe of the recorder, which discards everything recorded. Each request is a one-cycle pulse. The hold time is two or four seconds, chosen by a parameter. It is counted in cycles of the system clock, nominally 384 kHz. A second parameter gives the clock rate, so a simulation can use a much shorter count.

The same block drives the enable of an open-drain status lamp from the recorder's operating state. The lamp is dark when idle and lit solid while recording. During playback it follows a digital loudness bit taken from the output audio. During a wipe it blinks at 2 Hz.

Top module: `rstkey_led`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `playClr`, `sysClr` and the key tracking state are all zero.
- R2: A key press of 1 to HOLD_CLKS-1 consecutive sampled-low clock edges produces exactly one `playClr` pulse. The pulse is one cycle wide and visible right after the first edge that samples `keyN` high again. No `sysClr` is produced.
- R3: On the HOLD_CLKS-th consecutive edge that samples `keyN` low, `sysClr` is high for exactly one cycle. It does not repeat however long the key stays down.
- R4: Releasing a key that already produced `sysClr` produces no `playClr`.
- R5: HOLD_CLKS equals HOLD_SEC × CLK_HZ. HOLD_SEC may only be 2 or 4.
- R6: With `opState` = 0 (idle), `ledOe` is 0, so the open-drain lamp line floats and the lamp is dark.
- R7: With `opState` = 1 (recording), `ledOe` is 1, so the lamp is lit.
- R8: With `opState` = 2 (playing), `ledOe` equals `audioLoud` in the same cycle.
- R9: With `opState` = 3 (wiping), `ledOe` is 1 for the first CLK_HZ/4 edges spent in that state. It then alternates every CLK_HZ/4 edges. The phase restarts each time the state is entered.
- R10: `playClr` and `sysClr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 384 kHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| keyN | input | 1 | Debounced reset key, low while pressed |
| opState | input | 2 | Operating state: 0 idle, 1 recording, 2 playing, 3 wiping |
| audioLoud | input | 1 | Loudness bit of the output audio |
| playClr | output | 1 | One-cycle request to rewind the play counter |
| sysClr | output | 1 | One-cycle request for a full system wipe |
| ledOe | output | 1 | Lamp pull-down enable (1 = lamp on, 0 = line floats) |

## Verification
The two key pulses come from registers. `sysClr` is due right after the HOLD_CLKS-th low-sampling edge, and `playClr` right after the first high-sampling edge. The bench drives the key on falling edges and compares both pulses after every rising edge, for each press length from one cycle to past the threshold. `ledOe` is combinational from the state and the loudness bit, so it is checked one nanosecond after the inputs change. The blink phase is checked after each rising edge against the edge count since the wiping state was entered.

// File: rtl/rstkey_pkg.sv
package rstkey_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REC  = 2'd1,
    ST_PLAY = 2'd2,
    ST_WIPE = 2'd3
  } opState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;
    logic holdInc;
    logic flashRun;
  } ctlStrobe_t;

endpackage

// File: rtl/rstkey_dp.sv
module rstkey_dp
  import rstkey_pkg::*;
#(
  parameter int HOLD_CLKS  = 768000,
  parameter int FLASH_CLKS = 96000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  output logic       holdHit,
  output logic       flashPh
);

  localparam int HW = $clog2(HOLD_CLKS + 1);
  localparam int FW = (FLASH_CLKS > 1) ? $clog2(FLASH_CLKS) : 1;

  logic [HW-1:0] holdCnt;
  logic [FW-1:0] flashCnt;

  // press-length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdCnt <= '0;
    else if (stb.holdClr) holdCnt <= '0;
    else if (stb.holdInc) holdCnt <= holdCnt + 1'b1;
  end

  assign holdHit = (holdCnt == HW'(HOLD_CLKS - 1));

  // blink phase counter, phase 1 = lamp on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCnt <= '0;
      flashPh  <= 1'b1;
    end else if (!stb.flashRun) begin
      flashCnt <= '0;
      flashPh  <= 1'b1;
    end else if (flashCnt == FW'(FLASH_CLKS - 1)) begin
      flashCnt <= '0;
      flashPh  <= ~flashPh;
    end else begin
      flashCnt <= flashCnt + 1'b1;
    end
  end

  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HW'(HOLD_CLKS)) else $error("hold count overran"); // R3

  AST_FLASH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.flashRun) |-> flashPh) else $error("blink phase not restarted"); // R9

endmodule

// File: rtl/rstkey_ctl.sv
module rstkey_ctl
  import rstkey_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyN,
  input  opState_t   st,
  input  logic       audioLoud,
  input  logic       holdHit,
  input  logic       flashPh,
  output ctlStrobe_t stb,
  output logic       playClr,
  output logic       sysClr,
  output logic       ledOe
);

  logic keyDown;
  logic keyHeld;
  logic longDone;
  logic hitNow;

  assign keyDown = ~keyN;
  assign hitNow  = keyDown & ~longDone & holdHit;

  always_comb begin
    stb.holdClr  = ~keyDown;
    stb.holdInc  = keyDown & ~longDone;
    stb.flashRun = (st == ST_WIPE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyHeld  <= 1'b0;
      longDone <= 1'b0;
      sysClr   <= 1'b0;
      playClr  <= 1'b0;
    end else begin
      keyHeld  <= keyDown;
      longDone <= keyDown & (longDone | hitNow);
      sysClr   <= hitNow;
      playClr  <= ~keyDown & keyHeld & ~longDone;
    end
  end

  always_comb begin
    unique case (st)
      ST_IDLE: ledOe = 1'b0;
      ST_REC:  ledOe = 1'b1;
      ST_PLAY: ledOe = audioLoud;
      ST_WIPE: ledOe = flashPh;
      default: ledOe = 1'b0;
    endcase
  end

  AST_SYS_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    sysClr |=> !sysClr) else $error("wipe pulse repeated"); // R3

  AST_SYS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    sysClr |-> !$past(keyN)) else $error("wipe without held key"); // R3

  AST_PLAY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    playClr |-> $past(keyN)) else $error("rewind without release"); // R2

  AST_PLAY_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    playClr |=> !playClr) else $error("rewind pulse repeated"); // R2

  AST_NO_LONG_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    (longDone && keyN) |=> !playClr) else $error("rewind after wipe"); // R4

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(playClr && sysClr)) else $error("both pulses"); // R10

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE) |-> !ledOe) else $error("lamp lit when idle"); // R6

  AST_REC_LIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REC) |-> ledOe) else $error("lamp dark while recording"); // R7

endmodule

// File: rtl/rstkey_led.sv
module rstkey_led
  import rstkey_pkg::*;
#(
  parameter int CLK_HZ   = 384000,
  parameter int HOLD_SEC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyN,
  input  logic [1:0] opState,
  input  logic       audioLoud,
  output logic       playClr,
  output logic       sysClr,
  output logic       ledOe
);

  localparam int HOLD_CLKS  = HOLD_SEC * CLK_HZ;
  localparam int FLASH_CLKS = (CLK_HZ / 4 > 0) ? CLK_HZ / 4 : 1;

  initial begin
    AST_HOLD_SEC: assert (HOLD_SEC == 2 || HOLD_SEC == 4)
      else $error("HOLD_SEC must be 2 or 4"); // R5
  end

  opState_t   st;
  ctlStrobe_t stb;
  logic       holdHit;
  logic       flashPh;

  assign st = opState_t'(opState);

  rstkey_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .keyN      (keyN),
    .st        (st),
    .audioLoud (audioLoud),
    .holdHit   (holdHit),
    .flashPh   (flashPh),
    .stb       (stb),
    .playClr   (playClr),
    .sysClr    (sysClr),
    .ledOe     (ledOe)
  );

  rstkey_dp #(
    .HOLD_CLKS  (HOLD_CLKS),
    .FLASH_CLKS (FLASH_CLKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .holdHit (holdHit),
    .flashPh (flashPh)
  );

endmodule

// File: tb/sim_rstkey_led.sv
`timescale 1ns/1ps
module sim_rstkey_led;

  localparam int CLK_HZ   = 8;
  localparam int HOLD_SEC = 2;
  localparam int HOLD     = CLK_HZ * HOLD_SEC;  // R5: 16 edges
  localparam int FLASH    = CLK_HZ / 4;         // 2 edges

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       keyN = 1'b1;
  logic [1:0] opState = 2'd0;
  logic       audioLoud = 1'b0;
  logic       playClr, sysClr, ledOe;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rstkey_led #(.CLK_HZ(CLK_HZ), .HOLD_SEC(HOLD_SEC)) u0 (
    .clk(clk), .rstN(rstN), .keyN(keyN), .opState(opState),
    .audioLoud(audioLoud), .playClr(playClr), .sysClr(sysClr), .ledOe(ledOe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic stepNeg();
    @(posedge clk);
    @(negedge clk);
  endtask

  // press for c sampled edges, then release and watch
  task automatic press(input int c);
    keyN = 1'b0;
    for (int i = 1; i <= c; i++) begin
      stepNeg();
      check((i == HOLD) ? "R3" : "R3_quiet", sysClr, (i == HOLD));
      check("R2_nopulse_while_held", playClr, 1'b0);
      check("R10", playClr & sysClr, 1'b0);
    end
    keyN = 1'b1;
    stepNeg();
    if (c < HOLD) check("R2", playClr, 1'b1);
    else          check("R4", playClr, 1'b0);
    check("R2_nowipe", sysClr, 1'b0);
    stepNeg();
    check("R2_single", playClr, 1'b0);
    check("R3_single", sysClr, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", playClr, 1'b0);
    check("R1", sysClr, 1'b0);
    keyN = 1'b0;  // key down during reset must not count
    stepNeg();
    rstN = 1'b1;
    keyN = 1'b1;
    stepNeg();
    check("R1", playClr, 1'b0);
    check("R1", sysClr, 1'b0);

    // R2, R3, R4, R5: sweep press lengths across the threshold
    for (int c = 1; c <= HOLD + 4; c++) begin
      press(c);
    end

    // R6, R7, R8: lamp per state and loudness
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 2; a++) begin
        @(negedge clk);
        opState = 2'(s);
        audioLoud = 1'(a);
        #1;
        case (s)
          0: check("R6", ledOe, 1'b0);
          1: check("R7", ledOe, 1'b1);
          default: check("R8", ledOe, 1'(a));
        endcase
      end
    end

    // R9: blink in wiping state, entered twice
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk);
      opState = 2'd3;
      audioLoud = 1'b0;
      #1;
      for (int k = 0; k < 13; k++) begin
        check("R9", ledOe, ((k / FLASH) % 2) == 0);
        stepNeg();
      end
      opState = 2'd0;
      stepNeg();
      check("R6", ledOe, 1'b0);
    end

    finishRun();
  end

endmodule